// File: doc/BRIEF.md
# Pin-Level I/O Controller with Per-Pin Interrupt Triggers

This block controls a bank of general-purpose pins through a flat register bus. Software chooses which pins are outputs, drives output levels through separate write-one-to-set and write-one-to-clear registers, and reads back the resynchronised input levels. Output bits therefore never need a read-modify-write.

Each pin can also raise an interrupt. Three per-pin configuration bits choose the trigger: an edge or level method, a both-edges flag, and a polarity bit. A pin may trigger on a rising edge, a falling edge, either edge, a high level or a low level. Pending events collect in a raw status register, which is gated by a per-pin enable. A mask register filters the raw status into a masked view, and any masked bit that is set raises the single interrupt line.

The bus reads combinationally from the byte address. Writes take effect at the rising clock edge while the write enable is high.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every pin is an input, every output level is 0, and the interrupt line is 0. The enable, mask, raw status, method, both-edges and polarity registers all read 0, which selects a single rising edge.
- R2: The register byte offsets are: 0x04 synchronised inputs (read only), 0x08 direction, 0x10 set, 0x14 clear, 0x20 enable, 0x24 raw status, 0x28 masked status, 0x2C mask, 0x30 acknowledge, 0x34 method, 0x38 both-edges, 0x3C polarity. Direction bit 1 makes a pin an output, and the `pinDir` port mirrors the direction register.
- R3: A write to offset 0x10 sets to 1 every output bit whose data bit is 1. A write to 0x14 sets to 0 every output bit whose data bit is 1. Output bits whose data bit is 0 keep their value, and no other write changes the outputs.
- R4: Each pin input passes through a two-flop synchroniser. The value of offset 0x04 still shows the previous input one clock after a change and shows the new input two clocks after it.
- R5: With method bit 0 (edge), both-edges bit 0 and polarity bit 0, a rising edge on an enabled pin sets its raw status bit, and a falling edge does not.
- R6: With method bit 0, both-edges bit 0 and polarity bit 1, only a falling edge sets the raw bit.
- R7: With method bit 0 and both-edges bit 1, either edge sets the raw bit, whatever the polarity bit holds.
- R8: With method bit 1 (level), the raw bit is 1 while the pin is active: high for polarity 0, low for polarity 1. An acknowledge written while the pin is active leaves the bit at 1. The bit returns to 0 once the pin is inactive.
- R9: An edge-triggered raw bit stays set until a 1 is written to its bit at offset 0x30, which clears it.
- R10: A pin whose enable bit is 0 never sets its raw status bit.
- R11: The masked status reads raw AND NOT mask, and `irqOut` is 1 exactly when any masked status bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 8 | Register byte address |
| wrEn | input | 1 | Write strobe |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data |
| pinIn | input | 32 | Asynchronous pin levels |
| pinOut | output | 32 | Output level per pin |
| pinDir | output | 32 | Output enable per pin (1 = output) |
| irqOut | output | 1 | Combined interrupt |

## Verification
The trigger logic is tested with one pin stepped through all five trigger settings. Each setting receives a rising edge and a falling edge, so a swapped polarity or a lost both-edges override shows as a wrong status bit. Level mode is driven with an acknowledge written while the level is active, which distinguishes a held level from a latched edge. Separate patterns use a disabled pin and a masked pin, to separate the enable gate from the mask. A step on the inputs is read back one and two clocks later to pin down the synchroniser depth.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_INPUT  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_DIR    = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_SET    = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_CLR    = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_EN     = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_RAW    = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_MASKED = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_MASK   = 8'h2C;
  localparam logic [ADDR_W-1:0] OFS_ACK    = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_METHOD = 8'h34;
  localparam logic [ADDR_W-1:0] OFS_BOTH   = 8'h38;
  localparam logic [ADDR_W-1:0] OFS_POL    = 8'h3C;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_INPUT, SEL_DIR, SEL_EN, SEL_RAW, SEL_MASKED,
    SEL_MASK, SEL_METHOD, SEL_BOTH, SEL_POL
  } rdSel_e;

  typedef struct packed {
    logic   dirWr;
    logic   setWr;
    logic   clrWr;
    logic   enWr;
    logic   maskWr;
    logic   ackWr;
    logic   methodWr;
    logic   bothWr;
    logic   polWr;
    rdSel_e rdSel;
  } ctrlStrobe_t;
endpackage

// File: rtl/gpio_irq_decode.sv
module gpio_irq_decode
  import gpio_irq_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              wrEn,
  output ctrlStrobe_t       stb
);
  always_comb begin
    stb = '0;
    stb.rdSel = SEL_NONE;
    unique case (busAddr)
      OFS_INPUT:  stb.rdSel = SEL_INPUT;
      OFS_DIR:    begin stb.rdSel = SEL_DIR;    stb.dirWr    = wrEn; end
      OFS_SET:    stb.setWr = wrEn;
      OFS_CLR:    stb.clrWr = wrEn;
      OFS_EN:     begin stb.rdSel = SEL_EN;     stb.enWr     = wrEn; end
      OFS_RAW:    stb.rdSel = SEL_RAW;
      OFS_MASKED: stb.rdSel = SEL_MASKED;
      OFS_MASK:   begin stb.rdSel = SEL_MASK;   stb.maskWr   = wrEn; end
      OFS_ACK:    stb.ackWr = wrEn;
      OFS_METHOD: begin stb.rdSel = SEL_METHOD; stb.methodWr = wrEn; end
      OFS_BOTH:   begin stb.rdSel = SEL_BOTH;   stb.bothWr   = wrEn; end
      OFS_POL:    begin stb.rdSel = SEL_POL;    stb.polWr    = wrEn; end
      default:    stb.rdSel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/gpio_irq_datapath.sv
module gpio_irq_datapath
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         stb,
  input  logic [NUM_PINS-1:0] wrData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] rdData,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinDir,
  output logic                irqOut,
  output logic [NUM_PINS-1:0] rawStat,
  output logic [NUM_PINS-1:0] enBits
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [NUM_PINS-1:0] syncQ [SYNC_STAGES];
  logic [NUM_PINS-1:0] pinNow, pinPrev;
  logic [NUM_PINS-1:0] maskBits, methodBits, bothBits, polBits;
  logic [NUM_PINS-1:0] ackBits, rawNext, maskedStat;

  // input synchroniser chain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ[0] <= '0;
    else       syncQ[0] <= pinIn;
  end
  for (genvar s = 1; s < SYNC_STAGES; s++) begin : gSync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ[s] <= '0;
      else       syncQ[s] <= syncQ[s-1];
    end
  end
  assign pinNow = syncQ[LAST];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinPrev <= '0;
    else       pinPrev <= pinNow;
  end

  // configuration and output registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinDir     <= '0;
      pinOut     <= '0;
      enBits     <= '0;
      maskBits   <= '0;
      methodBits <= '0;
      bothBits   <= '0;
      polBits    <= '0;
    end else begin
      if (stb.dirWr)    pinDir     <= wrData;
      if (stb.setWr)    pinOut     <= pinOut | wrData;
      if (stb.clrWr)    pinOut     <= pinOut & ~wrData;
      if (stb.enWr)     enBits     <= wrData;
      if (stb.maskWr)   maskBits   <= wrData;
      if (stb.methodWr) methodBits <= wrData;
      if (stb.bothWr)   bothBits   <= wrData;
      if (stb.polWr)    polBits    <= wrData;
    end
  end

  assign ackBits = stb.ackWr ? wrData : '0;

  // per-pin trigger evaluation
  for (genvar p = 0; p < NUM_PINS; p++) begin : gPin
    logic riseEv, fallEv, edgeHit, levelAct;
    assign riseEv   = pinNow[p] & ~pinPrev[p];
    assign fallEv   = ~pinNow[p] & pinPrev[p];
    assign edgeHit  = bothBits[p] ? (riseEv | fallEv)
                                  : (polBits[p] ? fallEv : riseEv);
    assign levelAct = polBits[p] ? ~pinNow[p] : pinNow[p];
    assign rawNext[p] = methodBits[p]
                      ? (enBits[p] & levelAct)
                      : ((rawStat[p] & ~ackBits[p]) | (enBits[p] & edgeHit));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rawStat <= '0;
    else       rawStat <= rawNext;
  end

  assign maskedStat = rawStat & ~maskBits;
  assign irqOut     = |maskedStat;

  always_comb begin
    unique case (stb.rdSel)
      SEL_INPUT:  rdData = pinNow;
      SEL_DIR:    rdData = pinDir;
      SEL_EN:     rdData = enBits;
      SEL_RAW:    rdData = rawStat;
      SEL_MASKED: rdData = maskedStat;
      SEL_MASK:   rdData = maskBits;
      SEL_METHOD: rdData = methodBits;
      SEL_BOTH:   rdData = bothBits;
      SEL_POL:    rdData = polBits;
      default:    rdData = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                wrEn,
  input  logic [NUM_PINS-1:0] wrData,
  output logic [NUM_PINS-1:0] rdData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinDir,
  output logic                irqOut
);
  ctrlStrobe_t         stb;
  logic [NUM_PINS-1:0] rawStat, enBits;

  gpio_irq_decode uDec (
    .busAddr(busAddr),
    .wrEn   (wrEn),
    .stb    (stb)
  );

  gpio_irq_datapath #(
    .NUM_PINS   (NUM_PINS),
    .SYNC_STAGES(SYNC_STAGES)
  ) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .wrData (wrData),
    .pinIn  (pinIn),
    .rdData (rdData),
    .pinOut (pinOut),
    .pinDir (pinDir),
    .irqOut (irqOut),
    .rawStat(rawStat),
    .enBits (enBits)
  );
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic [ADDR_W-1:0]   busAddr,
  input logic                wrEn,
  input logic [NUM_PINS-1:0] wrData,
  input logic [NUM_PINS-1:0] pinOut,
  input logic                irqOut,
  input logic [NUM_PINS-1:0] rawStat,
  input logic [NUM_PINS-1:0] enBits
);
  assert_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && busAddr == OFS_SET) |=> ((pinOut & $past(wrData)) == $past(wrData)));

  assert_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && busAddr == OFS_CLR) |=> ((pinOut & $past(wrData)) == '0));

  assert_out_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && (busAddr == OFS_SET || busAddr == OFS_CLR)) |=> $stable(pinOut));

  assert_raw_gate_R10: assert property (@(posedge clk) disable iff (!rstN)
    ((rawStat & ~$past(rawStat) & ~$past(enBits)) == '0));

  assert_irq_source_R11: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (rawStat != '0));
endmodule

bind gpio_irq_ctrl gpio_irq_chk #(.NUM_PINS(NUM_PINS)) uChk (
  .clk    (clk),
  .rstN   (rstN),
  .busAddr(busAddr),
  .wrEn   (wrEn),
  .wrData (wrData),
  .pinOut (pinOut),
  .irqOut (irqOut),
  .rawStat(rawStat),
  .enBits (enBits)
);

// File: tb/sim_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [31:0] pinIn = '0;
  logic [31:0] pinOut, pinDir;
  logic        irqOut;
  int          checks = 0;
  int          errors = 0;

  localparam logic [7:0] A_IN = 8'h04, A_DIR = 8'h08, A_SET = 8'h10, A_CLR = 8'h14,
    A_EN = 8'h20, A_RAW = 8'h24, A_MSKD = 8'h28, A_MASK = 8'h2C, A_ACK = 8'h30,
    A_METH = 8'h34, A_BOTH = 8'h38, A_POL = 8'h3C;

  always #2.5 clk = ~clk;

  gpio_irq_ctrl u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .pinIn(pinIn), .pinOut(pinOut), .pinDir(pinDir), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; wrEn = 1'b0;
    #1 d = rdData;
  endtask

  task automatic drivePins(input logic [31:0] v);
    @(negedge clk);
    pinIn = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic expReg(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic testReset();
    check("R1 pinOut", pinOut, 32'h0);
    check("R1 pinDir", pinDir, 32'h0);
    check("R1 irqOut", {31'h0, irqOut}, 32'h0);
    expReg("R1 enable", A_EN, 32'h0);
    expReg("R1 mask", A_MASK, 32'h0);
    expReg("R1 raw", A_RAW, 32'h0);
    expReg("R1 method", A_METH, 32'h0);
    expReg("R1 both", A_BOTH, 32'h0);
    expReg("R1 polarity", A_POL, 32'h0);
  endtask

  task automatic testDir();
    wr(A_DIR, 32'hA5A5_0F0F);
    expReg("R2 direction readback", A_DIR, 32'hA5A5_0F0F);
    check("R2 pinDir port", pinDir, 32'hA5A5_0F0F);
    expReg("R2 unmapped reads zero", 8'h40, 32'h0);
  endtask

  task automatic testSetClr();
    wr(A_SET, 32'h0000_00F0);
    check("R3 set", pinOut, 32'h0000_00F0);
    wr(A_CLR, 32'h0000_0030);
    check("R3 clear", pinOut, 32'h0000_00C0);
    wr(A_SET, 32'h8000_0001);
    check("R3 set keeps others", pinOut, 32'h8000_00C1);
    wr(A_EN, 32'h0);
    check("R3 other write no effect", pinOut, 32'h8000_00C1);
  endtask

  task automatic testInput();
    logic [31:0] d;
    @(negedge clk);
    pinIn = 32'h1234_5678;
    rd(A_IN, d);
    check("R4 one clock still old", d, 32'h0);
    rd(A_IN, d);
    check("R4 two clocks new", d, 32'h1234_5678);
    drivePins(32'h0);
    expReg("R4 return low", A_IN, 32'h0);
  endtask

  task automatic testEdges();
    wr(A_EN, 32'h0000_0001);
    drivePins(32'h1);
    expReg("R5 rising sets raw", A_RAW, 32'h1);
    check("R5 irq", {31'h0, irqOut}, 32'h1);
    drivePins(32'h0);
    expReg("R9 raw held after fall", A_RAW, 32'h1);
    wr(A_ACK, 32'h1);
    expReg("R9 ack clears raw", A_RAW, 32'h0);
    check("R9 irq drops", {31'h0, irqOut}, 32'h0);

    wr(A_POL, 32'h1);
    drivePins(32'h1);
    expReg("R6 rise ignored in falling mode", A_RAW, 32'h0);
    drivePins(32'h0);
    expReg("R6 falling sets raw", A_RAW, 32'h1);
    wr(A_ACK, 32'h1);

    wr(A_BOTH, 32'h1);
    drivePins(32'h1);
    expReg("R7 both rise", A_RAW, 32'h1);
    wr(A_ACK, 32'h1);
    drivePins(32'h0);
    expReg("R7 both fall", A_RAW, 32'h1);
    wr(A_ACK, 32'h1);
    wr(A_BOTH, 32'h0);
    wr(A_POL, 32'h0);
    expReg("R9 all cleared", A_RAW, 32'h0);
  endtask

  task automatic testLevel();
    wr(A_EN, 32'h0000_0004);
    wr(A_METH, 32'h0000_0004);
    drivePins(32'h4);
    expReg("R8 high level raw", A_RAW, 32'h4);
    wr(A_ACK, 32'h4);
    expReg("R8 ack while active holds", A_RAW, 32'h4);
    drivePins(32'h0);
    expReg("R8 inactive drops", A_RAW, 32'h0);
    wr(A_POL, 32'h4);
    repeat (2) @(negedge clk);
    expReg("R8 low level raw", A_RAW, 32'h4);
    drivePins(32'h4);
    expReg("R8 low inactive drops", A_RAW, 32'h0);
    drivePins(32'h0);
    wr(A_METH, 32'h0);
    wr(A_POL, 32'h0);
    wr(A_ACK, 32'hFFFF_FFFF);
    expReg("R8 cleanup", A_RAW, 32'h0);
  endtask

  task automatic testEnable();
    wr(A_EN, 32'h0000_0001);
    drivePins(32'h8);
    expReg("R10 disabled pin no raw", A_RAW, 32'h0);
    check("R10 irq stays low", {31'h0, irqOut}, 32'h0);
    drivePins(32'h0);
  endtask

  task automatic testMask();
    wr(A_EN, 32'h0000_0010);
    wr(A_MASK, 32'h0000_0010);
    drivePins(32'h10);
    expReg("R11 raw set under mask", A_RAW, 32'h10);
    expReg("R11 masked hidden", A_MSKD, 32'h0);
    check("R11 irq masked", {31'h0, irqOut}, 32'h0);
    wr(A_MASK, 32'h0);
    expReg("R11 masked visible", A_MSKD, 32'h10);
    check("R11 irq raised", {31'h0, irqOut}, 32'h1);
    wr(A_ACK, 32'h10);
    check("R11 irq after ack", {31'h0, irqOut}, 32'h0);
  endtask

  initial begin
    #(5.0 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDir();
    testSetClr();
    testInput();
    testEdges();
    testLevel();
    testEnable();
    testMask();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule